// File: doc/BRIEF.md
# Three-Level Strap Pin Decoder

This block reads a short list of board strap pads at power-up. Each pad can be tied high, tied low or left unconnected. The block tells these three cases apart and packs the results into one base-3 number. For each pad in the list, it first turns on that pad's internal pull-up and waits for the pad to settle. It then samples the pad. Next it swaps to the internal pull-down, waits the same time and samples again.

If both samples are high, the pad is tied high. If both are low, it is tied low. If the two samples differ, the pad follows the internal pull and is floating. A tied-high pad is left with its pull-up on, and every other pad is left with its pull-down on. The result can encode up to 3^N board variants from N pads.

Software or a boot sequencer supplies three things: a start pulse, the number of list positions, and a pad index for each position. It then waits for the done pulse. The pad drivers themselves are outside the block: it only produces pull enables and reads synchronized pad levels.

Top module: `strap_decoder`

## Requirements
- R1: After reset, all pull-up and pull-down enables are 0, and `busy`, `done`, `error` and `value` are all 0.
- R2: For each list position, the selected pad first gets its pull-up alone for one settle window, then its pull-down alone for one settle window. No pad ever has both pulls enabled at once.
- R3: A pad is classified by its two samples. Pull-up sample 1 and pull-down sample 1 gives digit 2 (tied high). Both samples 0 gives digit 1 (tied low). Samples that differ give digit 0 (floating).
- R4: `value` equals the sum of digit(k)·3^k over list positions k = 0 to `pinCount`−1, so position 0 is the least significant digit. Position k's pad index is taken from `pinSel[k*PAD_W +: PAD_W]`.
- R5: When a decode ends, a pad classified tied-high has its pull-up only. Every other pad visited has its pull-down only. Pads not visited keep their previous pulls, and no pull changes while the block is idle.
- R6: Each settle window lasts W = (CLK_HZ/1e6)·SETTLE_US + SYNC_STAGES cycles. A decode of n positions holds `busy` high for exactly n·(2W+1)+1 cycles.
- R7: `done` pulses high for exactly one cycle, in the first cycle after `busy` falls. `value` and `error` change only in that cycle and then hold.
- R8: A `start` pulse that arrives while `busy` is high has no effect on the decode in progress.
- R9: If the pad index at position k is ≥ NUM_PADS, the decode stops at that position with `error`=1 and `value`=0. In this case `busy` lasts k·(2W+1)+1 cycles, and pads at positions below k still get their final pulls.
- R10: If `pinCount` > MAX_PINS, the decode fails at once with `error`=1 after one busy cycle, and no pull changes.
- R11: If `pinCount` = 0, the decode gives `value`=0 and `error`=0 after one busy cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; sampled only while idle |
| pinCount | input | CNT_W | Number of list positions to decode |
| pinSel | input | MAX_PINS*PAD_W | Pad index for each position; position k in bits [k*PAD_W +: PAD_W] |
| padIn | input | NUM_PADS | Raw pad levels (asynchronous) |
| pullUp | output | NUM_PADS | Per-pad pull-up enable |
| pullDn | output | NUM_PADS | Per-pad pull-down enable |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| value | output | RES_W | Decoded base-3 number |
| error | output | 1 | Last decode aborted on a bad index or count |

## Verification
The bench sweeps all 81 tie patterns over four positions, where a swapped digit code or a reversed weight order would show up at once. It then runs full eight-position lists, including the all-high maximum of 6560 that would overflow a narrow accumulator and lists with reversed and repeated pads. The busy length is counted cycle by cycle, so a settle window that ignores the synchronizer latency, or an extra state per pin, shows as a wrong count. The bench also checks pull order inside the window, the pulls left after each decode, and the abort cases. A design that stopped late on a bad index, cleared earlier pulls, or accepted a restart mid-run would report wrong pulls, value or duration.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_UPWAIT,
    ST_DNWAIT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadJob;
    logic armUp;
    logic armDn;
    logic takeHigh;
    logic commit;
    logic finish;
    logic flagErr;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic listEnd;
    logic padBad;
    logic settled;
  } seqStatus_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t status,
  output seqStrobe_t strb,
  output logic       busy
);

  seqState_e state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadJob = 1'b1;
          nextState    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.listEnd) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end else if (status.padBad) begin
          strb.finish  = 1'b1;
          strb.flagErr = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          strb.armUp = 1'b1;
          nextState  = ST_UPWAIT;
        end
      end
      ST_UPWAIT: begin
        if (status.settled) begin
          strb.takeHigh = 1'b1;
          strb.armDn    = 1'b1;
          nextState     = ST_DNWAIT;
        end
      end
      ST_DNWAIT: begin
        if (status.settled) begin
          strb.commit = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int SETTLE_US   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_PADS    = 6,
  parameter int PAD_W       = 3,
  parameter int MAX_PINS    = 8,
  parameter int RES_W       = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic [NUM_PADS-1:0]       padIn,
  input  logic [$clog2(MAX_PINS+1)-1:0] pinCount,
  input  logic [MAX_PINS*PAD_W-1:0] pinSel,
  output seqStatus_t                status,
  output logic [NUM_PADS-1:0]       pullUp,
  output logic [NUM_PADS-1:0]       pullDn,
  output logic [RES_W-1:0]          value,
  output logic                      error,
  output logic                      done
);

  localparam int CNT_W    = $clog2(MAX_PINS+1);
  localparam int PIDX_W   = (MAX_PINS > 1) ? $clog2(MAX_PINS) : 1;
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * SETTLE_US + SYNC_STAGES;
  localparam int CT_W     = $clog2(WAIT_CYC + 1);

  logic [NUM_PADS-1:0]       padSync;
  logic [CNT_W-1:0]          countQ, idxQ;
  logic [MAX_PINS*PAD_W-1:0] selQ;
  logic [PAD_W-1:0]          curPad;
  logic [CT_W-1:0]           settleQ;
  logic [RES_W-1:0]          accQ, multQ;
  logic                      hiQ, padVal, isHigh, isLow, padInRange;
  logic [NUM_PADS-1:0]       upQ, dnQ;
  logic [RES_W-1:0]          valueQ;
  logic                      errQ, doneQ;

  strap_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (padIn),
    .dout(padSync)
  );

  // pad index of the current list position
  assign curPad = selQ[idxQ[PIDX_W-1:0]*PAD_W +: PAD_W];

  always_comb begin
    padVal = 1'b0;
    for (int p = 0; p < NUM_PADS; p++)
      if (PAD_W'(p) == curPad) padVal = padSync[p];
  end

  assign padInRange = ({1'b0, curPad} < (PAD_W+1)'(NUM_PADS));
  assign isHigh     = hiQ & padVal;
  assign isLow      = ~hiQ & ~padVal;

  assign status.listEnd = (idxQ == countQ);
  assign status.padBad  = (countQ > CNT_W'(MAX_PINS)) || !padInRange;
  assign status.settled = (settleQ == '0);

  // job registers, settle timer, digit accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      idxQ    <= '0;
      selQ    <= '0;
      settleQ <= '0;
      accQ    <= '0;
      multQ   <= '0;
      hiQ     <= 1'b0;
    end else begin
      if (strb.loadJob) begin
        countQ <= pinCount;
        selQ   <= pinSel;
        idxQ   <= '0;
        accQ   <= '0;
        multQ  <= RES_W'(1);
      end
      if (strb.armUp || strb.armDn)
        settleQ <= CT_W'(WAIT_CYC - 1);
      else if (settleQ != '0)
        settleQ <= settleQ - 1'b1;
      if (strb.takeHigh)
        hiQ <= padVal;
      if (strb.commit) begin
        if (isHigh)
          accQ <= accQ + {multQ[RES_W-2:0], 1'b0};
        else if (isLow)
          accQ <= accQ + multQ;
        multQ <= multQ + {multQ[RES_W-2:0], 1'b0};
        idxQ  <= idxQ + 1'b1;
      end
    end
  end

  // per-pad pull enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= '0;
      dnQ <= '0;
    end else begin
      for (int p = 0; p < NUM_PADS; p++) begin
        if (PAD_W'(p) == curPad) begin
          if (strb.armUp) begin
            upQ[p] <= 1'b1;
            dnQ[p] <= 1'b0;
          end else if (strb.armDn) begin
            upQ[p] <= 1'b0;
            dnQ[p] <= 1'b1;
          end else if (strb.commit && isHigh) begin
            upQ[p] <= 1'b1;
            dnQ[p] <= 1'b0;
          end
        end
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valueQ <= '0;
      errQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.finish;
      if (strb.finish) begin
        valueQ <= strb.flagErr ? '0 : accQ;
        errQ   <= strb.flagErr;
      end
    end
  end

  assign pullUp = upQ;
  assign pullDn = dnQ;
  assign value  = valueQ;
  assign error  = errQ;
  assign done   = doneQ;

endmodule

// File: rtl/strap_decoder.sv
module strap_decoder
  import strap_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int SETTLE_US   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_PADS    = 6,
  parameter int PAD_W       = 3,
  parameter int MAX_PINS    = 8,
  parameter int RES_W       = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [$clog2(MAX_PINS+1)-1:0] pinCount,
  input  logic [MAX_PINS*PAD_W-1:0]     pinSel,
  input  logic [NUM_PADS-1:0]           padIn,
  output logic [NUM_PADS-1:0]           pullUp,
  output logic [NUM_PADS-1:0]           pullDn,
  output logic                          busy,
  output logic                          done,
  output logic [RES_W-1:0]              value,
  output logic                          error
);

  seqStrobe_t strb;
  seqStatus_t status;

  strap_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .status(status),
    .strb  (strb),
    .busy  (busy)
  );

  strap_datapath #(
    .CLK_HZ     (CLK_HZ),
    .SETTLE_US  (SETTLE_US),
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_PADS   (NUM_PADS),
    .PAD_W      (PAD_W),
    .MAX_PINS   (MAX_PINS),
    .RES_W      (RES_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .padIn   (padIn),
    .pinCount(pinCount),
    .pinSel  (pinSel),
    .status  (status),
    .pullUp  (pullUp),
    .pullDn  (pullDn),
    .value   (value),
    .error   (error),
    .done    (done)
  );

endmodule

// File: rtl/strap_decoder_check.sv
module strap_decoder_check #(
  parameter int NUM_PADS = 6,
  parameter int MAX_PINS = 8,
  parameter int RES_W    = 13
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                done,
  input logic                error,
  input logic [RES_W-1:0]    value,
  input logic [NUM_PADS-1:0] pullUp,
  input logic [NUM_PADS-1:0] pullDn
);

  function automatic longint pow3(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction

  localparam longint MAX_VAL = pow3(MAX_PINS) - 1;

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDn) == '0);                                   // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                            // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));                           // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(value) && $stable(error)));              // R7
  AST_ERR_VALUE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (value == '0));                         // R9
  AST_PULL_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(pullUp) && $stable(pullDn)));            // R5
  AST_VALUE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    longint'(value) <= MAX_VAL);                                // R4

endmodule

bind strap_decoder strap_decoder_check #(
  .NUM_PADS(NUM_PADS),
  .MAX_PINS(MAX_PINS),
  .RES_W   (RES_W)
) uCheck (
  .clk   (clk),
  .rstN  (rstN),
  .busy  (busy),
  .done  (done),
  .error (error),
  .value (value),
  .pullUp(pullUp),
  .pullDn(pullDn)
);

// File: tb/strap_decoder_test.sv
module strap_decoder_test;

  localparam int NP = 6, MP = 8, PW = 3, RW = 13, CW = 4;
  localparam int PHASE = 7;              // 1 MHz * 5 us + 2 sync stages
  localparam int PIN_CYC = 2 * PHASE + 1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CW-1:0]    pinCount = '0;
  logic [MP*PW-1:0] pinSel = '0;
  logic [NP-1:0]    padIn, pullUp, pullDn;
  logic             busy, done, error;
  logic [RW-1:0]    value;

  int tie [NP];                          // 0 float, 1 tied low, 2 tied high
  logic [NP-1:0] expUp = '0, expDn = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;                  // 125 MHz

  for (genvar g = 0; g < NP; g++) begin : gPad
    assign padIn[g] = (tie[g] == 2) ? 1'b1 : (tie[g] == 1) ? 1'b0 : pullUp[g];
  end

  strap_decoder #(
    .CLK_HZ(1_000_000), .SETTLE_US(5), .SYNC_STAGES(2),
    .NUM_PADS(NP), .PAD_W(PW), .MAX_PINS(MP), .RES_W(RW)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .pinCount(pinCount),
    .pinSel(pinSel), .padIn(padIn), .pullUp(pullUp), .pullDn(pullDn),
    .busy(busy), .done(done), .value(value), .error(error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runJob(input int count, input int sel [MP], input bit poke);
    int errAt = -1, nDone, expBusy, expVal = 0, w = 1, busyCnt = 0, cyc = 0;
    bit sawDone = 0, expErr;
    logic [MP*PW-1:0] packed_sel = '0;
    for (int k = 0; k < MP; k++) packed_sel[k*PW +: PW] = PW'(sel[k]);
    if (count > MP) errAt = 0;
    else
      for (int k = 0; k < count; k++)
        if (errAt < 0 && sel[k] >= NP) errAt = k;
    nDone   = (errAt >= 0) ? errAt : count;
    expErr  = (errAt >= 0);
    expBusy = nDone * PIN_CYC + 1;
    for (int k = 0; k < nDone; k++) begin
      expVal += tie[sel[k]] * w;
      w *= 3;
    end
    if (expErr) expVal = 0;

    @(negedge clk);
    start = 1'b1; pinCount = CW'(count); pinSel = packed_sel;
    @(negedge clk);
    start = 1'b0;
    while (!sawDone && cyc < 5000) begin
      if (done) sawDone = 1;
      else begin
        if (busy) busyCnt++;
        if (nDone > 0 && busyCnt == 2)   // R2 pull-up phase first
          check(pullUp[sel[0]] && !pullDn[sel[0]], "R2", "pull-up phase",
                int'({pullUp[sel[0]], pullDn[sel[0]]}), 2);
        if (nDone > 0 && busyCnt == PHASE + 2)   // R2 pull-down phase next
          check(!pullUp[sel[0]] && pullDn[sel[0]], "R2", "pull-down phase",
                int'({pullUp[sel[0]], pullDn[sel[0]]}), 1);
        if (poke && busyCnt == 5) begin start = 1'b1; pinCount = '0; end
        else start = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    check(sawDone, "R7", "done seen", int'(sawDone), 1);
    check(!busy, "R7", "busy low at done", int'(busy), 0);
    check(busyCnt == expBusy, expErr ? "R9" : (count == 0 ? "R11" : "R6"),
          "busy length", busyCnt, expBusy);
    check(value == RW'(expVal), "R4", "value", int'(value), expVal);
    check(error == expErr, count > MP ? "R10" : "R9", "error", int'(error), int'(expErr));
    for (int k = 0; k < nDone; k++) begin
      expUp[sel[k]] = (tie[sel[k]] == 2);
      expDn[sel[k]] = (tie[sel[k]] != 2);
    end
    @(negedge clk);
    check(!done, "R7", "done one cycle", int'(done), 0);
    check(pullUp == expUp && pullDn == expDn, "R5", "final pulls",
          int'({pullUp, pullDn}), int'({expUp, expDn}));
    check(value == RW'(expVal), "R7", "value held", int'(value), expVal);
  endtask

  initial begin
    #(8 * 150_000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s [MP];
    int held;
    for (int p = 0; p < NP; p++) tie[p] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pullUp == '0 && pullDn == '0, "R1", "pulls in reset", int'({pullUp, pullDn}), 0);
    check(!busy && !done && !error, "R1", "flags in reset", int'({busy, done, error}), 0);
    check(value == '0, "R1", "value in reset", int'(value), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pullUp == '0 && pullDn == '0 && !busy, "R1", "after release",
          int'({pullUp, pullDn}), 0);

    // R3 R4: every tie pattern on four positions
    s = '{0, 1, 2, 3, 4, 5, 0, 1};
    for (int v = 0; v < 81; v++) begin
      int r = v;
      for (int k = 0; k < 4; k++) begin tie[k] = r % 3; r = r / 3; end
      runJob(4, s, 0);
    end

    // R4 full-length lists: all high, mixed, reversed
    for (int p = 0; p < NP; p++) tie[p] = 2;
    runJob(8, s, 0);
    tie = '{2, 0, 1, 2, 1, 0};
    runJob(8, s, 0);
    s = '{5, 4, 3, 2, 1, 0, 5, 4};
    runJob(8, s, 0);
    s = '{1, 1, 3, 0, 2, 2, 5, 4};
    runJob(6, s, 0);

    // R8 restart request while busy is ignored
    s = '{3, 0, 2, 0, 0, 0, 0, 0};
    runJob(3, s, 1);

    // R9 bad pad index at position 2, and at position 0
    tie = '{1, 2, 0, 2, 0, 1};
    s = '{3, 5, 6, 0, 0, 0, 0, 0};
    runJob(4, s, 0);
    s = '{7, 0, 0, 0, 0, 0, 0, 0};
    runJob(1, s, 0);

    // R10 count above the list size
    runJob(9, s, 0);

    // R11 empty list
    runJob(0, s, 0);

    // R5 R7: idle holds pulls and result
    held = int'(value);
    repeat (20) @(negedge clk);
    check(pullUp == expUp && pullDn == expDn, "R5", "idle pulls",
          int'({pullUp, pullDn}), int'({expUp, expDn}));
    check(int'(value) == held && !done, "R7", "idle value", int'(value), held);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule